// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Logic

This block sits beside a RAM shared by two ports. It holds the top two words of that RAM's address space. Each port uses these words to leave a message for the other port.

The word at the all-ones address is the right port's mailbox. The word one below it is the left port's mailbox. When a port writes into the other side's mailbox, the owner's interrupt line goes active. The owner reads its own mailbox to fetch the message, and that read drops the interrupt. Each interrupt output is active-low and is driven directly by a flop.

The address width is a parameter, so the mailbox locations always follow the depth of the RAM. All other addresses belong to the RAM proper, and the block ignores them.

Top module: `mbox_irq`

## Requirements
- R1: After reset, both interrupt outputs are high, both mailbox words are zero and both read-data outputs are zero.
- R2: A left-port write to the all-ones address (right mailbox) drives `irq_r_n` low from the next clock edge on.
- R3: A right-port write to the all-ones-minus-one address (left mailbox) drives `irq_l_n` low from the next clock edge on.
- R4: A port that reads its own mailbox returns its interrupt output high at the next clock edge.
- R5: A port that writes its own mailbox leaves both interrupt outputs unchanged. The word is still stored.
- R6: When one cycle sets a flag and also clears it by the owner's read, the flag ends up set.
- R7: A read presents data on that port's `rd_*` one clock later. A mailbox address returns the word stored before that edge. Any other address returns zero. `rd_*` holds its value in cycles with no read.
- R8: Writes and reads to non-mailbox addresses change neither flag nor either mailbox word.
- R9: When both ports write the same mailbox in one cycle, the non-owner's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_l | input | 1 | Left port access enable |
| we_l | input | 1 | Left write (1) / read (0) |
| addr_l | input | AW | Left word address |
| wd_l | input | DW | Left write data |
| rd_l | output | DW | Left read data |
| en_r | input | 1 | Right port access enable |
| we_r | input | 1 | Right write (1) / read (0) |
| addr_r | input | AW | Right word address |
| wd_r | input | DW | Right write data |
| rd_r | output | DW | Right read data |
| irq_l_n | output | 1 | Left interrupt, active-low |
| irq_r_n | output | 1 | Right interrupt, active-low |

## Verification
The assertions assume that the enable, write and address inputs are stable, known values at every clock edge once reset is released. The bench therefore changes inputs only on falling edges and never leaves them undriven. The set-wins and same-cycle write cases rely on both ports acting in the same cycle. The stimulus drives each port in every cycle, with deliberate overlaps on one mailbox address.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_l,
  input  logic          we_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] wd_l,
  output logic [DW-1:0] rd_l,
  input  logic          en_r,
  input  logic          we_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wd_r,
  output logic [DW-1:0] rd_r,
  output logic          irq_l_n,
  output logic          irq_r_n
);
  localparam logic [AW-1:0] BOX_R = '1;
  localparam logic [AW-1:0] BOX_L = BOX_R - 1'b1;

  logic [DW-1:0] box_l, box_r;

  wire wr_l_boxl = en_l & we_l & (addr_l == BOX_L);
  wire wr_l_boxr = en_l & we_l & (addr_l == BOX_R);
  wire rd_l_boxl = en_l & ~we_l & (addr_l == BOX_L);
  wire wr_r_boxl = en_r & we_r & (addr_r == BOX_L);
  wire wr_r_boxr = en_r & we_r & (addr_r == BOX_R);
  wire rd_r_boxr = en_r & ~we_r & (addr_r == BOX_R);

  function automatic logic [DW-1:0] pick(input logic [AW-1:0] a,
                                         input logic [DW-1:0] bl,
                                         input logic [DW-1:0] br);
    if (a == BOX_L) return bl;
    if (a == BOX_R) return br;
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      box_l   <= '0;
      box_r   <= '0;
      rd_l    <= '0;
      rd_r    <= '0;
      irq_l_n <= 1'b1;
      irq_r_n <= 1'b1;
    end else begin
      if (wr_r_boxl)      box_l <= wd_r;
      else if (wr_l_boxl) box_l <= wd_l;
      if (wr_l_boxr)      box_r <= wd_l;
      else if (wr_r_boxr) box_r <= wd_r;
      if (en_l && !we_l) rd_l <= pick(addr_l, box_l, box_r);
      if (en_r && !we_r) rd_r <= pick(addr_r, box_l, box_r);
      if (wr_r_boxl)      irq_l_n <= 1'b0;
      else if (rd_l_boxl) irq_l_n <= 1'b1;
      if (wr_l_boxr)      irq_r_n <= 1'b0;
      else if (rd_r_boxr) irq_r_n <= 1'b1;
    end
  end

  assert_set_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_l && we_l && addr_l == BOX_R) |=> !irq_r_n);
  assert_set_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && we_r && addr_r == BOX_L) |=> !irq_l_n);
  assert_clear_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && !we_r && addr_r == BOX_R && !(en_l && we_l && addr_l == BOX_R)) |=> irq_r_n);
  assert_clear_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_l && !we_l && addr_l == BOX_L && !(en_r && we_r && addr_r == BOX_L)) |=> irq_l_n);
  assert_own_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && we_r && addr_r == BOX_R && !(en_l && we_l && addr_l == BOX_R)) |=> $stable(irq_r_n));
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_l && we_l && addr_l == BOX_R && en_r && !we_r && addr_r == BOX_R) |=> !irq_r_n);
endmodule

// File: tb/mbox_irq_tb.sv
module mbox_irq_tb;
  localparam int AW = 15;
  localparam int DW = 16;
  localparam logic [AW-1:0] ML = 15'h7FFE;
  localparam logic [AW-1:0] MR = 15'h7FFF;

  logic clk = 0, rst_n = 0;
  logic en_l = 0, we_l = 0, en_r = 0, we_r = 0;
  logic [AW-1:0] addr_l = '0, addr_r = '0;
  logic [DW-1:0] wd_l = '0, wd_r = '0;
  logic [DW-1:0] rd_l, rd_r;
  logic irq_l_n, irq_r_n;

  always #5 clk = ~clk;

  mbox_irq #(.AW(AW), .DW(DW)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW+DW+1:0] expq[$];
  string tagq[$];

  logic [DW-1:0] mb_l = 0, mb_r = 0, e_rl = 0, e_rr = 0;
  logic f_l = 0, f_r = 0;

  task automatic cyc(input logic el, wl, input logic [AW-1:0] al, input logic [DW-1:0] dl,
                     input logic er, wr, input logic [AW-1:0] ar, input logic [DW-1:0] dr,
                     input string tag);
    logic sl, cl, sr, cr;
    @(negedge clk);
    en_l = el; we_l = wl; addr_l = al; wd_l = dl;
    en_r = er; we_r = wr; addr_r = ar; wd_r = dr;
    if (el && !wl) e_rl = (al == ML) ? mb_l : (al == MR) ? mb_r : '0;
    if (er && !wr) e_rr = (ar == ML) ? mb_l : (ar == MR) ? mb_r : '0;
    sr = el && wl && al == MR;  cr = er && !wr && ar == MR;
    sl = er && wr && ar == ML;  cl = el && !wl && al == ML;
    f_r = sr | (f_r & !cr);
    f_l = sl | (f_l & !cl);
    if (sr) mb_r = dl; else if (er && wr && ar == MR) mb_r = dr;
    if (sl) mb_l = dr; else if (el && wl && al == ML) mb_l = dl;
    @(posedge clk);
    expq.push_back({e_rl, e_rr, !f_l, !f_r});
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [DW+DW+1:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if ({rd_l, rd_r, irq_l_n, irq_r_n} !== e) begin
        errors++;
        $display("FAIL %s: got rd_l=%h rd_r=%h irq_l_n=%b irq_r_n=%b exp rd_l=%h rd_r=%h irq_l_n=%b irq_r_n=%b",
                 t, rd_l, rd_r, irq_l_n, irq_r_n, e[2*DW+1:DW+2], e[DW+1:2], e[1], e[0]);
      end
    end
  end

  task automatic idle(input string tag);
    cyc(0, 0, '0, '0, 0, 0, '0, '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    checks++;
    if ({rd_l, rd_r, irq_l_n, irq_r_n} !== {16'h0, 16'h0, 2'b11}) begin
      errors++;
      $display("FAIL R1: got %h %h %b%b exp 0 0 11", rd_l, rd_r, irq_l_n, irq_r_n);
    end
    cyc(1, 0, ML, 0, 1, 0, MR, 0, "R1 mailboxes read zero");
    cyc(1, 1, MR, 16'hA5A5, 0, 0, 0, 0, "R2 left writes right box");
    idle("R2 flag held");
    cyc(0, 0, 0, 0, 1, 0, MR, 0, "R4 right reads own box, R7 data");
    idle("R4 flag stays clear");
    cyc(0, 0, 0, 0, 1, 1, ML, 16'h1234, "R3 right writes left box");
    cyc(1, 0, ML, 0, 0, 0, 0, 0, "R4 left reads own box, R7 data");
    cyc(1, 1, ML, 16'h5555, 0, 0, 0, 0, "R5 left writes own box");
    cyc(0, 0, 0, 0, 1, 1, MR, 16'h7777, "R5 right writes own box");
    cyc(1, 0, ML, 0, 1, 0, MR, 0, "R5 stored words readable");
    cyc(1, 1, MR, 16'hBEEF, 1, 0, MR, 0, "R6 set beats clear right");
    cyc(1, 0, ML, 0, 1, 1, ML, 16'hCAFE, "R6 set beats clear left");
    cyc(1, 1, 15'h0010, 16'hFFFF, 1, 1, 15'h7FFD, 16'hFFFF, "R8 non-box writes ignored");
    cyc(1, 0, 15'h0010, 0, 1, 0, 15'h7FFD, 0, "R7 non-box reads zero");
    idle("R7 rd holds");
    cyc(1, 0, ML, 0, 1, 0, MR, 0, "R8 boxes unchanged, R4 both clear");
    cyc(1, 1, MR, 16'h0101, 1, 1, MR, 16'h0202, "R9 right box non-owner wins");
    cyc(1, 1, ML, 16'h0303, 1, 1, ML, 16'h0404, "R9 left box non-owner wins");
    cyc(1, 0, ML, 0, 1, 0, MR, 0, "R9 read back, R4 clear");
    cyc(1, 1, 15'h0000, 16'h9999, 1, 0, 15'h0000, 0, "R8 low address");
    idle("final");
    idle("drain");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule